// File: doc/BRIEF.md
# Gapped Strided Copy Engine

This block moves a programmed number of bytes from a source region to a destination region. Both regions are laid out as lines: a line is a run of bytes that is copied, and between lines lies a gap that is skipped. Each side has its own line width and gap, so a line on the source side can end in the middle of a line on the destination side. Software places the two base addresses, the byte count and the four shape values on the configuration pins, then pulses `start`. When the copy ends, the engine raises `done` for one cycle.

Data moves in 16-byte beats. Addresses are beat addresses, so byte address = beat address × 16, and widths and gaps are counted in 16-byte units. The engine has at most one beat in flight. It issues a read request, takes the read response, and then offers the write. Every channel is valid/ready. A valid signal, once raised, stays high with its payload unchanged until the cycle in which ready is also high, and the transfer completes on that edge. The read response channel is the reverse case: the engine holds `rd_rsp_ready` high while it waits. Back-pressure on any channel only stretches the copy. It never changes the data moved.

Top module: `gsc_engine`

## Requirements
- R1: After reset `done`, `done_err`, `rd_req_valid`, `rd_rsp_ready` and `wr_valid` are all low.
- R2: The engine reads source beats starting at `cfg_src_addr` and writes destination beats starting at `cfg_dst_addr`. Line widths and gaps are taken as multiples of 16 bytes (one beat each).
- R3: A start is rejected when the input width, the output width or the size is zero, or when either base address is not below `ADDR_LIMIT`. A rejected start issues no read or write. `done` and `done_err` are both high in the cycle after the start edge.
- R4: Each beat moves min(remaining bytes of the source line, remaining bytes of the destination line, remaining total bytes, 16) bytes.
- R5: When the source line is used up, the source address skips forward by the input gap and the line count reloads to the input width.
- R6: When the destination line is used up, the destination address skips forward by the output gap and the line count reloads to the output width.
- R7: No byte in a destination gap, and no byte beyond the total size, is written. No source beat that lies wholly in a gap is read.
- R8: After the write handshake of the last beat, `done` is high for exactly one cycle, in the next cycle, with `done_err` low.
- R9: A `start` that arrives while a copy is in progress is ignored.
- R10: `rd_req_valid` and `wr_valid` hold, with address, data and strobes stable, until they are accepted. At most one of `rd_req_valid`, `rd_rsp_ready` and `wr_valid` is high at a time.
- R11: Write strobes are contiguous from byte 0, with bit k enabling `wr_data[8k+7:8k]`. A final beat of n < 16 bytes has only its low n strobe bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_addr | input | AW | Source base, beat address |
| cfg_dst_addr | input | AW | Destination base, beat address |
| cfg_size | input | SW | Total bytes to copy |
| cfg_in_width | input | LW | Source line width, 16-byte units |
| cfg_in_gap | input | LW | Source gap, 16-byte units |
| cfg_out_width | input | LW | Destination line width, 16-byte units |
| cfg_out_gap | input | LW | Destination gap, 16-byte units |
| start | input | 1 | Start pulse, sampled while idle |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | With done: the start was rejected |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request ready |
| rd_req_addr | output | AW | Read beat address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine can take read data |
| rd_rsp_data | input | 128 | Read beat data, byte k in bits 8k+7:8k |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write ready |
| wr_addr | output | AW | Write beat address |
| wr_data | output | 128 | Write beat data |
| wr_strb | output | 16 | Byte enables |

## Verification
A wrong line counter or gap adder on the source side shows up at `rd_req_addr` on the first read after a source line ends. The destination side shows the same fault at `wr_addr` on the first write after a destination line ends. The bench compares the whole destination image against a byte-by-byte model, and it checks every read address against the set of beats the model touched. A remaining-size counter that is off appears as a wrong strobe on the last beat, or as `done` arriving one beat early or late. A state machine that takes a second start while busy changes the destination image of that same copy.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  localparam int BEAT_BYTES = 16;
  localparam int BEAT_BITS  = BEAT_BYTES * 8;
  localparam int CHUNK_W    = $clog2(BEAT_BYTES) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_RSP,
    ST_WR,
    ST_FIN
  } gsc_state_e;
endpackage

// File: rtl/gsc_cfg_check.sv
module gsc_cfg_check #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 24,
  parameter logic [AW-1:0] ADDR_LIMIT = '1
) (
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [SW-1:0] size,
  input  logic [LW-1:0] in_width,
  input  logic [LW-1:0] out_width,
  output logic          cfg_ok
);
  logic shape_ok;
  logic addr_ok;

  always_comb begin
    shape_ok = (in_width != '0) && (out_width != '0) && (size != '0);
    addr_ok  = (src_addr < ADDR_LIMIT) && (dst_addr < ADDR_LIMIT);
    cfg_ok   = shape_ok && addr_ok;
  end
endmodule

// File: rtl/gsc_side.sv
module gsc_side #(
  parameter int AW = 32,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] width_u,
  input  logic [LW-1:0] gap_u,
  input  logic          step,
  output logic [AW-1:0] addr,
  output logic [LW-1:0] left_u
);
  logic [LW-1:0] width_q;
  logic [LW-1:0] gap_q;
  logic          line_end;

  assign line_end = (left_u == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      left_u  <= '0;
      width_q <= '0;
      gap_q   <= '0;
    end else if (load) begin
      addr    <= base;
      left_u  <= width_u;
      width_q <= width_u;
      gap_q   <= gap_u;
    end else if (step) begin
      if (line_end) begin
        left_u <= width_q;
        addr   <= addr + AW'(1) + AW'(gap_q);
      end else begin
        left_u <= left_u - LW'(1);
        addr   <= addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/gsc_chunk.sv
module gsc_chunk
  import gsc_pkg::*;
#(
  parameter int LW = 12,
  parameter int SW = 24
) (
  input  logic [LW-1:0]         in_left_u,
  input  logic [LW-1:0]         out_left_u,
  input  logic [SW-1:0]         rem,
  output logic [CHUNK_W-1:0]    chunk,
  output logic [BEAT_BYTES-1:0] strb
);
  localparam int MW = ((LW + 4) > SW) ? (LW + 4) : SW;

  logic [MW-1:0] in_b;
  logic [MW-1:0] out_b;
  logic [MW-1:0] rem_b;
  logic [MW-1:0] m1;
  logic [MW-1:0] m2;

  always_comb begin
    in_b  = MW'({in_left_u, 4'b0000});
    out_b = MW'({out_left_u, 4'b0000});
    rem_b = MW'(rem);
    m1    = (in_b < out_b) ? in_b : out_b;
    m2    = (m1 < rem_b) ? m1 : rem_b;
    chunk = (m2 >= MW'(BEAT_BYTES)) ? CHUNK_W'(BEAT_BYTES) : m2[CHUNK_W-1:0];
  end

  for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_strb
    assign strb[k] = (CHUNK_W'(k) < chunk);
  end
endmodule

// File: rtl/gsc_engine.sv
module gsc_engine
  import gsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int SW = 24,
  parameter logic [AW-1:0] ADDR_LIMIT = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         cfg_src_addr,
  input  logic [AW-1:0]         cfg_dst_addr,
  input  logic [SW-1:0]         cfg_size,
  input  logic [LW-1:0]         cfg_in_width,
  input  logic [LW-1:0]         cfg_in_gap,
  input  logic [LW-1:0]         cfg_out_width,
  input  logic [LW-1:0]         cfg_out_gap,
  input  logic                  start,
  output logic                  done,
  output logic                  done_err,
  output logic                  rd_req_valid,
  input  logic                  rd_req_ready,
  output logic [AW-1:0]         rd_req_addr,
  input  logic                  rd_rsp_valid,
  output logic                  rd_rsp_ready,
  input  logic [BEAT_BITS-1:0]  rd_rsp_data,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [AW-1:0]         wr_addr,
  output logic [BEAT_BITS-1:0]  wr_data,
  output logic [BEAT_BYTES-1:0] wr_strb
);
  gsc_state_e state_q, state_d;

  logic                 cfg_ok;
  logic                 accept;
  logic                 load;
  logic                 step;
  logic                 last_beat;
  logic                 err_q;
  logic [SW-1:0]        rem_q;
  logic [BEAT_BITS-1:0] data_q;
  logic [CHUNK_W-1:0]   chunk;

  logic [1:0][AW-1:0] side_base;
  logic [1:0][LW-1:0] side_width;
  logic [1:0][LW-1:0] side_gap;
  logic [1:0][AW-1:0] side_addr;
  logic [1:0][LW-1:0] side_left;

  assign side_base  = {cfg_dst_addr, cfg_src_addr};
  assign side_width = {cfg_out_width, cfg_in_width};
  assign side_gap   = {cfg_out_gap, cfg_in_gap};

  gsc_cfg_check #(
    .AW(AW), .LW(LW), .SW(SW), .ADDR_LIMIT(ADDR_LIMIT)
  ) u_check (
    .src_addr (cfg_src_addr),
    .dst_addr (cfg_dst_addr),
    .size     (cfg_size),
    .in_width (cfg_in_width),
    .out_width(cfg_out_width),
    .cfg_ok   (cfg_ok)
  );

  // side 0 walks the source, side 1 walks the destination
  for (genvar s = 0; s < 2; s++) begin : g_side
    gsc_side #(.AW(AW), .LW(LW)) u_side (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .base   (side_base[s]),
      .width_u(side_width[s]),
      .gap_u  (side_gap[s]),
      .step   (step),
      .addr   (side_addr[s]),
      .left_u (side_left[s])
    );
  end

  gsc_chunk #(.LW(LW), .SW(SW)) u_chunk (
    .in_left_u (side_left[0]),
    .out_left_u(side_left[1]),
    .rem       (rem_q),
    .chunk     (chunk),
    .strb      (wr_strb)
  );

  assign accept    = (state_q == ST_IDLE) && start;
  assign load      = accept && cfg_ok;
  assign step      = (state_q == ST_WR) && wr_ready;
  assign last_beat = (rem_q <= SW'(chunk));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = cfg_ok ? ST_RD_REQ : ST_FIN;
      ST_RD_REQ: if (rd_req_ready) state_d = ST_RD_RSP;
      ST_RD_RSP: if (rd_rsp_valid) state_d = ST_WR;
      ST_WR:     if (wr_ready) state_d = last_beat ? ST_FIN : ST_RD_REQ;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      rem_q   <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) err_q <= !cfg_ok;
      if (load) rem_q <= cfg_size;
      else if (step) rem_q <= rem_q - SW'(chunk);
      if ((state_q == ST_RD_RSP) && rd_rsp_valid) data_q <= rd_rsp_data;
    end
  end

  assign rd_req_valid = (state_q == ST_RD_REQ);
  assign rd_rsp_ready = (state_q == ST_RD_RSP);
  assign wr_valid     = (state_q == ST_WR);
  assign rd_req_addr  = side_addr[0];
  assign wr_addr      = side_addr[1];
  assign wr_data      = data_q;
  assign done         = (state_q == ST_FIN);
  assign done_err     = (state_q == ST_FIN) && err_q;
endmodule

// File: rtl/gsc_engine_chk.sv
module gsc_engine_chk #(
  parameter int AW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           done,
  input logic           rd_req_valid,
  input logic           rd_req_ready,
  input logic [AW-1:0]  rd_req_addr,
  input logic           rd_rsp_ready,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic [AW-1:0]  wr_addr,
  input logic [127:0]   wr_data,
  input logic [15:0]    wr_strb
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_strb));

  // R10
  single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req_valid, rd_rsp_ready, wr_valid}));

  // R11
  strb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_strb[0] && (((17'(wr_strb) + 17'd1) & 17'(wr_strb)) == 17'd0));
endmodule

bind gsc_engine gsc_engine_chk #(.AW(AW)) u_gsc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr),
  .rd_rsp_ready(rd_rsp_ready),
  .wr_valid    (wr_valid),
  .wr_ready    (wr_ready),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .wr_strb     (wr_strb)
);

// File: tb/test_gsc_engine.sv
module test_gsc_engine;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int SW = 24;
  localparam int NB = 256;
  localparam int NBYTE = NB * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [SW-1:0] cfg_size = '0;
  logic [LW-1:0] cfg_in_width = '0, cfg_in_gap = '0, cfg_out_width = '0, cfg_out_gap = '0;
  logic start = 1'b0;
  logic done, done_err, rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic wr_valid, wr_ready;
  logic [AW-1:0] rd_req_addr, wr_addr;
  logic [127:0] rd_rsp_data, wr_data;
  logic [15:0] wr_strb;

  gsc_engine #(.AW(AW), .LW(LW), .SW(SW), .ADDR_LIMIT(32'd256)) i_gsc_engine (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr), .cfg_size(cfg_size),
    .cfg_in_width(cfg_in_width), .cfg_in_gap(cfg_in_gap),
    .cfg_out_width(cfg_out_width), .cfg_out_gap(cfg_out_gap),
    .start(start), .done(done), .done_err(done_err),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] srcmem [NBYTE];
  logic [7:0] dstmem [NBYTE];
  logic [7:0] refmem [NBYTE];
  bit rd_ok [NB];
  int rd_cnt = 0, rd_bad = 0, wr_cnt = 0;
  logic [15:0] last_strb = '0;
  bit stall = 0;
  logic [3:0] cyc = '0;

  assign rd_req_ready = !stall || (cyc[1:0] == 2'd0);
  assign wr_ready     = !stall || (cyc[1:0] == 2'd2);

  // memory model: one-cycle read latency, strobed writes
  always @(posedge clk) begin
    cyc <= cyc + 4'd1;
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) begin
        rd_cnt <= rd_cnt + 1;
        if (rd_req_addr >= NB || !rd_ok[rd_req_addr]) rd_bad <= rd_bad + 1;
        rd_rsp_valid <= 1'b1;
        for (int k = 0; k < 16; k++)
          rd_rsp_data[8*k +: 8] <= (rd_req_addr < NB) ? srcmem[rd_req_addr*16 + k] : 8'h00;
      end else if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
      end
      if (wr_valid && wr_ready) begin
        wr_cnt <= wr_cnt + 1;
        last_strb <= wr_strb;
        for (int k = 0; k < 16; k++)
          if (wr_strb[k] && wr_addr < NB) dstmem[wr_addr*16 + k] = wr_data[8*k +: 8];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int src, input int dst, input int iw, input int ig,
                      input int ow, input int og, input int sz, output int nreads);
    int sp, dp, ri, ro;
    for (int i = 0; i < NBYTE; i++) begin dstmem[i] = 8'hEE; refmem[i] = 8'hEE; end
    for (int i = 0; i < NB; i++) rd_ok[i] = 0;
    sp = src * 16; dp = dst * 16; ri = iw * 16; ro = ow * 16;
    for (int n = 0; n < sz; n++) begin
      if (sp < NBYTE && dp < NBYTE) begin
        refmem[dp] = srcmem[sp];
        rd_ok[sp / 16] = 1;
      end
      sp++; dp++; ri--; ro--;
      if (ri == 0) begin ri = iw * 16; sp += ig * 16; end
      if (ro == 0) begin ro = ow * 16; dp += og * 16; end
    end
    nreads = 0;
    for (int i = 0; i < NB; i++) if (rd_ok[i]) nreads++;
  endtask

  task automatic drive_cfg(input int src, input int dst, input int iw, input int ig,
                           input int ow, input int og, input int sz);
    cfg_src_addr = AW'(src); cfg_dst_addr = AW'(dst); cfg_size = SW'(sz);
    cfg_in_width = LW'(iw); cfg_in_gap = LW'(ig);
    cfg_out_width = LW'(ow); cfg_out_gap = LW'(og);
  endtask

  task automatic run_copy(input string req, input int src, input int dst, input int iw,
                          input int ig, input int ow, input int og, input int sz,
                          input bit stl, input bit poke);
    int nreads, r0, t, bad;
    prep(src, dst, iw, ig, ow, og, sz, nreads);
    stall = stl;
    r0 = rd_cnt;
    @(negedge clk);
    drive_cfg(src, dst, iw, ig, ow, og, sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      drive_cfg(0, 0, 1, 0, 1, 0, 16);   // R9 second start while busy
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 5000) begin @(negedge clk); t++; end
    chk(t < 5000, req, "done seen", t, 0);
    chk(done_err == 1'b0, "R8", "done_err on good copy", done_err, 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done width", done, 0);
    bad = 0;
    for (int i = 0; i < NBYTE; i++) if (dstmem[i] !== refmem[i]) bad++;
    chk(bad == 0, req, "destination byte mismatches", bad, 0);
    chk(rd_bad == 0, "R7", "reads outside expected beats", rd_bad, 0);
    chk(rd_cnt - r0 == nreads, req, "read count", rd_cnt - r0, nreads);
    stall = 0;
  endtask

  task automatic run_reject(input string what, input int src, input int dst, input int iw,
                            input int ow, input int sz);
    int r0, w0, bad;
    prep(0, 0, 1, 0, 1, 0, 0, r0);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    drive_cfg(src, dst, iw, 0, ow, 0, sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && done_err, "R3", what, {done, done_err}, 3);
    @(negedge clk);
    chk(!done, "R3", "done drops after reject", done, 0);
    repeat (3) @(negedge clk);
    chk(rd_cnt == r0 && wr_cnt == w0, "R3", "no traffic on reject",
        (rd_cnt - r0) + (wr_cnt - w0), 0);
    bad = 0;
    for (int i = 0; i < NBYTE; i++) if (dstmem[i] !== 8'hEE) bad++;
    chk(bad == 0, "R3", "destination untouched", bad, 0);
  endtask

  task automatic t_reset;
    chk(!done && !done_err, "R1", "done idle", {done, done_err}, 0);
    chk(!rd_req_valid && !rd_rsp_ready && !wr_valid, "R1", "channels idle",
        {rd_req_valid, rd_rsp_ready, wr_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NBYTE; i++) srcmem[i] = 8'(i * 7 + 3 + i / 256);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    // R2 matching shapes, no gaps
    run_copy("R2", 0, 128, 4, 0, 4, 0, 64, 0, 0);
    // R5 source gaps, wide destination line
    run_copy("R5", 2, 130, 2, 1, 8, 0, 128, 0, 0);
    // R6 destination gaps
    run_copy("R6", 10, 140, 8, 0, 3, 2, 160, 0, 0);
    // R4 mismatched lines on both sides, partial final beat
    run_copy("R4", 20, 128, 3, 2, 2, 3, 200, 0, 0);
    chk(last_strb == 16'h00FF, "R11", "last strobe of 200-byte copy", last_strb, 16'h00FF);
    // R10 same copy with back-pressure on all channels
    run_copy("R10", 20, 128, 3, 2, 2, 3, 200, 1, 0);
    // R9 start while busy must not disturb the running copy
    run_copy("R9", 40, 160, 2, 1, 3, 1, 150, 1, 1);
    // R11 single short beat
    run_copy("R11", 5, 200, 1, 0, 1, 0, 5, 0, 0);
    chk(last_strb == 16'h001F, "R11", "strobe of 5-byte copy", last_strb, 16'h001F);
    run_reject("zero input width", 0, 128, 0, 1, 16);
    run_reject("zero output width", 0, 128, 1, 0, 16);
    run_reject("zero size", 0, 128, 1, 1, 0);
    run_reject("source address out of range", 300, 128, 1, 1, 16);
    run_reject("destination address out of range", 0, 256, 1, 1, 16);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule